// File: doc/BRIEF.md
# Configurable Registered Command/Address Buffer

This block is the clocked register that sits between a memory controller and the DRAM devices on a registered memory module. On every rising clock edge it captures the command and address inputs and drives them out again as registered outputs. Two static configuration inputs pick how it is used. In the wide one-to-one topology, each of the 25 data inputs feeds exactly one output. In the narrow one-to-two topology, only the lower 14 inputs are used, and each captured bit feeds two output copies, A and B.

In the one-to-two topology the register plays one of two roles on the module, the first register or the second. The role decides which two data positions carry the clock-enable and termination controls. In the wide topology those controls arrive on dedicated inputs. Controls and the registered chip select are always fanned out as an A and a B copy.

Two active-low chip selects act as a power gate. When both are inactive at an edge, the ordinary data outputs keep their previous state. The controls and the chip-select copies keep updating regardless. An active-low asynchronous reset clears every output at once. The outputs stay low until the first clock edge after reset is released. The configuration inputs are only expected to change while reset is held.

Top module: `crb_top`

## Requirements
- R1: With `mode_split` low (regardless of `mode_role`), each output `q_a[i]` for i = 0..24 takes `din[i]` one clock edge after capture, and `q_b` stays all zero.
- R2: With `mode_split` high, `q_a[i]` and `q_b[i]` both take `din[i]` for every non-control position i in 0..13, and `q_a[24:14]` stays all zero.
- R3: With `mode_split` high and `mode_role` low (first register), the clock-enable outputs take `din[0]` and the termination outputs take `din[3]`. Data outputs at positions 0 and 3 are held low, and `cke_in`/`odt_in` have no effect.
- R4: With `mode_split` high and `mode_role` high (second register), the termination outputs take `din[10]` and the clock-enable outputs take `din[13]`. Data outputs at positions 10 and 13 are held low, and `cke_in`/`odt_in` have no effect.
- R5: With `mode_split` low, the clock-enable outputs take `cke_in` and the termination outputs take `odt_in` one edge later.
- R6: At an edge where both `cs0_n` and `cs1_n` are high, `q_a` and `q_b` keep their previous values whatever `din` holds.
- R7: The clock-enable, termination and chip-select outputs update at every edge, including edges where the data outputs are frozen by R6.
- R8: `csq_a` and `csq_b` take the value of `cs0_n` one edge after capture.
- R9: While `rst_n` is low, all outputs are low without waiting for a clock edge, and they stay low until the first rising edge after `rst_n` returns high.
- R10: The A and B copies of clock-enable, termination and chip select are equal at every edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Capture clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_split | input | 1 | 0: 25-bit one-to-one, 1: 14-bit one-to-two |
| mode_role | input | 1 | In one-to-two: 0 first register, 1 second register |
| din | input | 25 | Command/address inputs, index i is position i+1 |
| cke_in | input | 1 | Dedicated clock-enable input used in one-to-one |
| odt_in | input | 1 | Dedicated termination input used in one-to-one |
| cs0_n | input | 1 | Chip select 0, active low, also registered out |
| cs1_n | input | 1 | Chip select 1, active low, gating only |
| q_a | output | 25 | Registered data, primary copy |
| q_b | output | 14 | Registered data, second copy in one-to-two |
| cke_a | output | 1 | Registered clock-enable, copy A |
| cke_b | output | 1 | Registered clock-enable, copy B |
| odt_a | output | 1 | Registered termination, copy A |
| odt_b | output | 1 | Registered termination, copy B |
| csq_a | output | 1 | Registered chip select 0, copy A |
| csq_b | output | 1 | Registered chip select 0, copy B |

## Verification
Chip-select freezing and control capture fall on the same edge whenever both selects are high. The data outputs must then hold while clock-enable, termination and chip-select outputs take fresh values. The bench provokes this with runs of gated cycles in every topology while `din`, `cke_in` and `odt_in` keep toggling. It judges each edge against a behavioural model that treats the frozen data and the moving controls separately. Asynchronous reset is also asserted mid-cycle on top of non-zero outputs, and its release is checked before the next edge.

// File: rtl/crb_pkg.sv
package crb_pkg;

    typedef enum logic [1:0] {
        CRB_WIDE   = 2'd0,
        CRB_PAIR_A = 2'd1,
        CRB_PAIR_B = 2'd2
    } crb_mode_e;

    // control positions inside the narrow input field (index = position - 1)
    localparam int unsigned POS_A_CKE = 0;
    localparam int unsigned POS_A_ODT = 3;
    localparam int unsigned POS_B_ODT = 10;
    localparam int unsigned POS_B_CKE = 13;

endpackage

// File: rtl/crb_mode_dec.sv
module crb_mode_dec
    import crb_pkg::*;
(
    input  logic      mode_split,
    input  logic      mode_role,
    output crb_mode_e mode
);

    always_comb begin
        if (!mode_split) begin
            mode = CRB_WIDE;
        end else if (mode_role) begin
            mode = CRB_PAIR_B;
        end else begin
            mode = CRB_PAIR_A;
        end
    end

endmodule

// File: rtl/crb_ctrl_pick.sv
module crb_ctrl_pick
    import crb_pkg::*;
#(
    parameter int unsigned NARROW_W = 14
) (
    input  crb_mode_e           mode,
    input  logic [NARROW_W-1:0] din_lo,
    input  logic                cke_in,
    input  logic                odt_in,
    output logic                cke_nx,
    output logic                odt_nx,
    output logic [NARROW_W-1:0] ctl_mask
);

    always_comb begin
        cke_nx   = cke_in;
        odt_nx   = odt_in;
        ctl_mask = '0;
        unique case (mode)
            CRB_PAIR_A: begin
                cke_nx              = din_lo[POS_A_CKE];
                odt_nx              = din_lo[POS_A_ODT];
                ctl_mask[POS_A_CKE] = 1'b1;
                ctl_mask[POS_A_ODT] = 1'b1;
            end
            CRB_PAIR_B: begin
                cke_nx              = din_lo[POS_B_CKE];
                odt_nx              = din_lo[POS_B_ODT];
                ctl_mask[POS_B_CKE] = 1'b1;
                ctl_mask[POS_B_ODT] = 1'b1;
            end
            default: begin
                cke_nx   = cke_in;
                odt_nx   = odt_in;
                ctl_mask = '0;
            end
        endcase
    end

endmodule

// File: rtl/crb_lane_route.sv
module crb_lane_route
    import crb_pkg::*;
#(
    parameter int unsigned WIDE_W   = 25,
    parameter int unsigned NARROW_W = 14
) (
    input  crb_mode_e           mode,
    input  logic                gate_open,
    input  logic [WIDE_W-1:0]   din,
    input  logic [NARROW_W-1:0] ctl_mask,
    input  logic [WIDE_W-1:0]   qa_cur,
    input  logic [NARROW_W-1:0] qb_cur,
    output logic [WIDE_W-1:0]   qa_nx,
    output logic [NARROW_W-1:0] qb_nx
);

    logic is_wide;
    assign is_wide = (mode == CRB_WIDE);

    for (genvar i = 0; i < WIDE_W; i++) begin : g_lane
        if (i < NARROW_W) begin : g_lo
            // shared lanes: primary copy plus second copy
            assign qa_nx[i] = (!is_wide && ctl_mask[i]) ? 1'b0
                            : (gate_open ? din[i] : qa_cur[i]);
            assign qb_nx[i] = (is_wide || ctl_mask[i]) ? 1'b0
                            : (gate_open ? din[i] : qb_cur[i]);
        end else begin : g_hi
            // upper lanes exist only in the wide topology
            assign qa_nx[i] = !is_wide ? 1'b0
                            : (gate_open ? din[i] : qa_cur[i]);
        end
    end

endmodule

// File: rtl/crb_top.sv
module crb_top
    import crb_pkg::*;
#(
    parameter int unsigned WIDE_W   = 25,
    parameter int unsigned NARROW_W = 14
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                mode_split,
    input  logic                mode_role,
    input  logic [WIDE_W-1:0]   din,
    input  logic                cke_in,
    input  logic                odt_in,
    input  logic                cs0_n,
    input  logic                cs1_n,
    output logic [WIDE_W-1:0]   q_a,
    output logic [NARROW_W-1:0] q_b,
    output logic                cke_a,
    output logic                cke_b,
    output logic                odt_a,
    output logic                odt_b,
    output logic                csq_a,
    output logic                csq_b
);

    typedef struct packed {
        logic [WIDE_W-1:0]   qa;
        logic [NARROW_W-1:0] qb;
        logic                cke_a;
        logic                cke_b;
        logic                odt_a;
        logic                odt_b;
        logic                cs_a;
        logic                cs_b;
    } crb_regs_t;

    crb_regs_t           st_d;
    crb_regs_t           st_q;
    crb_mode_e           mode;
    logic                gate_open;
    logic                cke_nx;
    logic                odt_nx;
    logic [NARROW_W-1:0] ctl_mask;
    logic [WIDE_W-1:0]   qa_nx;
    logic [NARROW_W-1:0] qb_nx;

    // data lanes move only when at least one select is active
    assign gate_open = !(cs0_n && cs1_n);

    crb_mode_dec u_dec (
        .mode_split (mode_split),
        .mode_role  (mode_role),
        .mode       (mode)
    );

    crb_ctrl_pick #(.NARROW_W(NARROW_W)) u_ctl (
        .mode     (mode),
        .din_lo   (din[NARROW_W-1:0]),
        .cke_in   (cke_in),
        .odt_in   (odt_in),
        .cke_nx   (cke_nx),
        .odt_nx   (odt_nx),
        .ctl_mask (ctl_mask)
    );

    crb_lane_route #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_route (
        .mode      (mode),
        .gate_open (gate_open),
        .din       (din),
        .ctl_mask  (ctl_mask),
        .qa_cur    (st_q.qa),
        .qb_cur    (st_q.qb),
        .qa_nx     (qa_nx),
        .qb_nx     (qb_nx)
    );

    always_comb begin
        st_d       = st_q;
        st_d.qa    = qa_nx;
        st_d.qb    = qb_nx;
        st_d.cke_a = cke_nx;
        st_d.cke_b = cke_nx;
        st_d.odt_a = odt_nx;
        st_d.odt_b = odt_nx;
        st_d.cs_a  = cs0_n;
        st_d.cs_b  = cs0_n;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign q_a   = st_q.qa;
    assign q_b   = st_q.qb;
    assign cke_a = st_q.cke_a;
    assign cke_b = st_q.cke_b;
    assign odt_a = st_q.odt_a;
    assign odt_b = st_q.odt_b;
    assign csq_a = st_q.cs_a;
    assign csq_b = st_q.cs_b;

endmodule

// File: rtl/crb_chk.sv
module crb_chk
    import crb_pkg::*;
#(
    parameter int unsigned WIDE_W   = 25,
    parameter int unsigned NARROW_W = 14
) (
    input logic                clk,
    input logic                rst_n,
    input logic                mode_split,
    input logic                mode_role,
    input logic [WIDE_W-1:0]   din,
    input logic                cke_in,
    input logic                odt_in,
    input logic                cs0_n,
    input logic                cs1_n,
    input logic [WIDE_W-1:0]   q_a,
    input logic [NARROW_W-1:0] q_b,
    input logic                cke_a,
    input logic                cke_b,
    input logic                odt_a,
    input logic                odt_b,
    input logic                csq_a,
    input logic                csq_b
);

    AST_WIDE_NO_COPY: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_split |-> q_b == '0); // R1

    AST_PAIR_COPY_EQ: assert property (@(posedge clk) disable iff (!rst_n)
        mode_split |-> q_a[NARROW_W-1:0] == q_b); // R2

    AST_PAIR_UPPER_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        mode_split |-> q_a[WIDE_W-1:NARROW_W] == '0); // R2

    AST_FIRST_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_split && !mode_role) |=> (cke_a == $past(din[POS_A_CKE]) && odt_a == $past(din[POS_A_ODT]))); // R3

    AST_SECOND_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_split && mode_role) |=> (cke_a == $past(din[POS_B_CKE]) && odt_a == $past(din[POS_B_ODT]))); // R4

    AST_WIDE_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_split |=> (cke_a == $past(cke_in) && odt_a == $past(odt_in))); // R5

    AST_FREEZE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (cs0_n && cs1_n) |=> ($stable(q_a) && $stable(q_b))); // R6

    AST_CS_FOLLOW: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (csq_a == $past(cs0_n) && csq_b == $past(cs0_n))); // R8

    AST_COPY_PAIRS: assert property (@(posedge clk) disable iff (!rst_n)
        (cke_a == cke_b) && (odt_a == odt_b) && (csq_a == csq_b)); // R10

    always @(posedge clk) begin
        if (!rst_n) begin
            AST_RESET_LOW: assert (q_a == '0 && q_b == '0 && !cke_a && !cke_b
                                   && !odt_a && !odt_b && !csq_a && !csq_b); // R9
        end
    end

endmodule

bind crb_top crb_chk #(.WIDE_W(WIDE_W), .NARROW_W(NARROW_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode_split (mode_split),
    .mode_role  (mode_role),
    .din        (din),
    .cke_in     (cke_in),
    .odt_in     (odt_in),
    .cs0_n      (cs0_n),
    .cs1_n      (cs1_n),
    .q_a        (q_a),
    .q_b        (q_b),
    .cke_a      (cke_a),
    .cke_b      (cke_b),
    .odt_a      (odt_a),
    .odt_b      (odt_b),
    .csq_a      (csq_a),
    .csq_b      (csq_b)
);

// File: tb/sim_crb_top.sv
`timescale 1ns/1ps
module sim_crb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b1;
    logic        mode_split = 1'b0;
    logic        mode_role = 1'b0;
    logic [24:0] din = '0;
    logic        cke_in = 1'b0;
    logic        odt_in = 1'b0;
    logic        cs0_n = 1'b1;
    logic        cs1_n = 1'b1;
    logic [24:0] q_a;
    logic [13:0] q_b;
    logic        cke_a, cke_b, odt_a, odt_b, csq_a, csq_b;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    // behavioural expectations
    logic [24:0] e_a = '0;
    logic [13:0] e_b = '0;
    logic        e_cke = 1'b0;
    logic        e_odt = 1'b0;
    logic        e_cs = 1'b0;

    always #2.5 clk = ~clk;

    crb_top u0 (
        .clk(clk), .rst_n(rst_n), .mode_split(mode_split), .mode_role(mode_role),
        .din(din), .cke_in(cke_in), .odt_in(odt_in), .cs0_n(cs0_n), .cs1_n(cs1_n),
        .q_a(q_a), .q_b(q_b), .cke_a(cke_a), .cke_b(cke_b), .odt_a(odt_a),
        .odt_b(odt_b), .csq_a(csq_a), .csq_b(csq_b)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic bit is_ctl(input int i);
        if (!mode_split) return 1'b0;
        if (!mode_role) return (i == 0 || i == 3);
        return (i == 10 || i == 13);
    endfunction

    task automatic check_zero(input string tag);
        chk({tag, " q_a"}, 32'(q_a), 32'd0);
        chk({tag, " q_b"}, 32'(q_b), 32'd0);
        chk({tag, " ctl"}, {26'd0, cke_a, cke_b, odt_a, odt_b, csq_a, csq_b}, 32'd0);
    endtask

    // one clock: model the edge, then compare at the falling edge
    task automatic cyc();
        bit open;
        string dtag, ctag;
        @(posedge clk);
        open = !(cs0_n && cs1_n);
        for (int i = 0; i < 25; i++) begin
            if (!mode_split) begin
                if (open) e_a[i] = din[i];
            end else if (i >= 14 || is_ctl(i)) begin
                e_a[i] = 1'b0;
            end else if (open) begin
                e_a[i] = din[i];
            end
        end
        for (int i = 0; i < 14; i++) begin
            if (!mode_split || is_ctl(i)) e_b[i] = 1'b0;
            else if (open) e_b[i] = din[i];
        end
        if (!mode_split) begin
            e_cke = cke_in; e_odt = odt_in;
        end else if (!mode_role) begin
            e_cke = din[0]; e_odt = din[3];
        end else begin
            e_cke = din[13]; e_odt = din[10];
        end
        e_cs = cs0_n;
        @(negedge clk);
        dtag = !open ? "R6 freeze" : (mode_split ? "R2 pair data" : "R1 wide data");
        ctag = !open ? "R7 ctrl while frozen" : (!mode_split ? "R5 wide ctrl" : (mode_role ? "R4 second ctrl" : "R3 first ctrl"));
        chk({dtag, " q_a"}, 32'(q_a), 32'(e_a));
        chk({dtag, " q_b"}, 32'(q_b), 32'(e_b));
        chk({ctag, " cke"}, 32'(cke_a), 32'(e_cke));
        chk({ctag, " odt"}, 32'(odt_a), 32'(e_odt));
        chk("R8 cs copy", {30'd0, csq_a, csq_b}, {30'd0, e_cs, e_cs});
        chk("R10 pair copies", {29'd0, cke_b, odt_b, csq_b}, {29'd0, e_cke, e_odt, e_cs});
        if (mode_split) begin
            if (!mode_role) chk("R3 ctl lanes low", {28'd0, q_a[0], q_a[3], q_b[0], q_b[3]}, 32'd0);
            else chk("R4 ctl lanes low", {28'd0, q_a[10], q_a[13], q_b[10], q_b[13]}, 32'd0);
        end
    endtask

    task automatic do_reset(input logic split, input logic role);
        @(negedge clk);
        #0.5 rst_n = 1'b0;
        #0.5 check_zero("R9 async clear");
        mode_split = split;
        mode_role = role;
        e_a = '0; e_b = '0; e_cke = 1'b0; e_odt = 1'b0; e_cs = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        din = 25'h1FFFFFF; cke_in = 1'b1; odt_in = 1'b1; cs0_n = 1'b0; cs1_n = 1'b0;
        #1 check_zero("R9 low until edge");
    endtask

    task automatic drive_rand(input int gate_pct);
        din = 25'($urandom());
        cke_in = 1'($urandom());
        odt_in = 1'($urandom());
        if (int'($urandom_range(99)) < gate_pct) begin
            cs0_n = 1'b1; cs1_n = 1'b1;
        end else begin
            case ($urandom_range(2))
                0: begin cs0_n = 1'b0; cs1_n = 1'b1; end
                1: begin cs0_n = 1'b1; cs1_n = 1'b0; end
                default: begin cs0_n = 1'b0; cs1_n = 1'b0; end
            endcase
        end
    endtask

    task automatic run_phase(input logic split, input logic role);
        do_reset(split, role);
        cyc();
        // directed: all ones then a frozen run with changing inputs
        for (int k = 0; k < 6; k++) begin
            din = ~din; cke_in = ~cke_in; odt_in = ~odt_in;
            cs0_n = 1'b1; cs1_n = 1'b1;
            cyc();
        end
        // only the second select active still opens the gate
        cs0_n = 1'b1; cs1_n = 1'b0; din = 25'h0AAAAAA;
        cyc();
        for (int k = 0; k < 80; k++) begin
            drive_rand(35);
            cyc();
        end
    endtask

    initial begin
        #1 rst_n = 1'b0;
        #0.5 check_zero("R9 initial");
        run_phase(1'b0, 1'b0);
        run_phase(1'b0, 1'b1);
        run_phase(1'b1, 1'b0);
        run_phase(1'b1, 1'b1);
        run_phase(1'b0, 1'b0);
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog expired act=running exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule